// File: doc/BRIEF.md
# Device-Paced Chunked DMA Channel

This block is a single DMA channel that moves data between a peripheral and memory, one chunk at a time, as the peripheral asks for it. Software sets up the transfer on the configuration inputs and pulses `arm`. The setup holds a source address, a destination address, a total byte count, an access-size code, a chunk length counted in accesses, one increment flag per address and a 4-bit priority.

The arm is checked first. If the byte count or either address does not line up with the access size, or if the count or chunk length is zero, the channel refuses to start and raises `cfg_err`. Once armed, each one-cycle pulse on `dev_req` makes the channel run one chunk through the memory port. A chunk is a series of read-then-write pairs at the programmed access size. After the last write of the chunk, the channel returns a one-cycle `dev_ack`. Requests that arrive while a chunk is running are counted and served afterwards, in order. Either address can be held fixed, which suits a peripheral data register, or can step by the access size after each access.

The controller is a five-state machine:

| State | Activity |
|-------|----------|
| `ST_IDLE` | No transfer is armed. |
| `ST_WAIT` | Armed, waiting for a request. |
| `ST_READ` | Read command on the memory port. |
| `ST_WRITE` | Write command on the memory port. |
| `ST_ACK` | One-cycle acknowledge. |

Its transitions are:

| From | To | Condition |
|------|----|-----------|
| `ST_IDLE` | `ST_WAIT` | Valid arm. |
| `ST_WAIT` | `ST_READ` | A new request or a pending request is present. |
| `ST_READ` | `ST_WRITE` | Read completes on `mem_ready`. |
| `ST_WRITE` | `ST_READ` | Write completes and more accesses remain in the chunk. |
| `ST_WRITE` | `ST_ACK` | Write completes and it was the last of the chunk. |
| `ST_ACK` | `ST_WAIT` | Bytes remain. |
| `ST_ACK` | `ST_IDLE` | The byte count is exhausted. |

Top module: `dev_chunk_dma`

## Requirements
- R1: `cfg_size` codes the access size as 0=1, 1=2, 2=4 and 3=8 bytes. Every access of a transfer uses that size, and `mem_size` carries the code unchanged during the transfer.
- R2: An arm in `ST_IDLE` is rejected if any of these holds:
  - `cfg_len` is not a multiple of the access size.
  - `cfg_src` or `cfg_dst` is not aligned to the access size.
  - `cfg_len` is zero.
  - `cfg_chunk` is zero.

  On rejection, `cfg_err` is 1 from the next cycle and the channel stays idle. A valid arm clears `cfg_err`.
- R3: Each accepted request produces `cfg_chunk` accesses. Each access is a read that completes on `mem_ready`, followed by a write of the same data that completes on `mem_ready`. The accesses are taken in address order.
- R4: When fewer accesses remain than `cfg_chunk`, the last request performs only the remaining accesses.
- R5: With `cfg_src_inc`=1, the source address of access k is `cfg_src` + k·size. With `cfg_src_inc`=0, it stays `cfg_src` for the whole transfer.
- R6: With `cfg_dst_inc`=1, the destination address of access k is `cfg_dst` + k·size. With `cfg_dst_inc`=0, it stays `cfg_dst` for the whole transfer.
- R7: Requests that arrive while a chunk is in progress are counted. Each is served later as its own chunk, with no further request needed.
- R8: `dev_ack` is a one-cycle pulse in the cycle after the last write of a chunk completes. `done` is high together with the ack of the final chunk, and `busy` is 0 from the next cycle.
- R9: `mem_prio` carries the programmed priority (0 to 15) on every access of the transfer.
- R10: `arm` while busy is ignored and changes neither `cfg_err` nor the transfer. `dev_req` while idle starts no memory access.
- R11: After reset, `busy`, `cfg_err`, `done`, `dev_ack`, `mem_rd_en` and `mem_wr_en` are all 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| arm | input | 1 | Pulse that arms a transfer with the current configuration |
| cfg_src | input | AW | Source start address |
| cfg_dst | input | AW | Destination start address |
| cfg_len | input | LEN_W | Total byte count |
| cfg_size | input | 2 | Access-size code |
| cfg_chunk | input | CHUNK_W | Accesses per request |
| cfg_src_inc | input | 1 | Source address advances after each access |
| cfg_dst_inc | input | 1 | Destination address advances after each access |
| cfg_prio | input | 4 | Transfer priority |
| busy | output | 1 | A transfer is armed and not finished |
| cfg_err | output | 1 | Last arm in idle was rejected |
| done | output | 1 | Final chunk acknowledged |
| dev_req | input | 1 | Device chunk request pulse |
| dev_ack | output | 1 | Chunk complete pulse |
| mem_rd_en | output | 1 | Read command |
| mem_wr_en | output | 1 | Write command |
| mem_addr | output | AW | Access address |
| mem_size | output | 2 | Access-size code |
| mem_prio | output | 4 | Access priority |
| mem_wr_data | output | DATA_W | Write data, low bytes significant |
| mem_rd_data | input | DATA_W | Read data, valid when `mem_ready` is high in a read |
| mem_ready | input | 1 | Current command completes this cycle |

## Verification
A wrong remaining-byte count or chunk count shows up at the ports within one chunk. It appears as a wrong number of writes before `dev_ack`, or as `done` arriving early or late. A wrong address register shows on the very next `mem_addr` of a read or write. A lost pending request shows as a missing acknowledge once the current chunk ends, because the channel then stalls in `ST_WAIT`. The bench sweeps every access size, both increment flags and full or partial final chunks under random memory stalls. For each of these it predicts every address, per-chunk write count and final memory image arithmetically.

// File: rtl/dcd_pkg.sv
package dcd_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_WAIT,
        ST_READ,
        ST_WRITE,
        ST_ACK
    } dcd_state_e;

    // access-size code to byte count
    function automatic logic [3:0] size_bytes(input logic [1:0] code);
        return 4'd1 << code;
    endfunction

endpackage

// File: rtl/dcd_param_check.sv
module dcd_param_check #(
    parameter int AW      = 32,
    parameter int LEN_W   = 24,
    parameter int CHUNK_W = 8
) (
    input  logic [AW-1:0]      src,
    input  logic [AW-1:0]      dst,
    input  logic [LEN_W-1:0]   len,
    input  logic [1:0]         size_code,
    input  logic [CHUNK_W-1:0] chunk,
    output logic               ok
);
    import dcd_pkg::*;

    logic [3:0] nbytes;
    logic [2:0] mask;
    logic       bad_len, bad_src, bad_dst;

    always_comb begin
        nbytes  = size_bytes(size_code);
        mask    = 3'(nbytes - 4'd1);
        bad_len = ((len[2:0] & mask) != 3'd0) || (len == '0);
        bad_src = (src[2:0] & mask) != 3'd0;
        bad_dst = (dst[2:0] & mask) != 3'd0;
        ok      = !bad_len && !bad_src && !bad_dst && (chunk != '0);
    end

endmodule

// File: rtl/dcd_addr_gen.sv
module dcd_addr_gen #(
    parameter int AW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [AW-1:0] load_addr,
    input  logic          load_inc,
    input  logic          step,
    input  logic [1:0]    size_code,
    output logic [AW-1:0] addr
);
    import dcd_pkg::*;

    logic          inc_q;
    logic [AW-1:0] stride;

    assign stride = {{(AW-4){1'b0}}, size_bytes(size_code)};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            addr  <= '0;
            inc_q <= 1'b0;
        end else if (load) begin
            addr  <= load_addr;
            inc_q <= load_inc;
        end else if (step && inc_q) begin
            addr  <= addr + stride;
        end
    end

endmodule

// File: rtl/dcd_pend_ctr.sv
module dcd_pend_ctr #(
    parameter int PEND_W = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic inc,
    input  logic dec,
    output logic nonzero
);
    localparam logic [PEND_W-1:0] PEND_MAX = {PEND_W{1'b1}};

    logic [PEND_W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (clr) begin
            cnt_q <= '0;
        end else begin
            unique case ({inc, dec})
                2'b10:   if (cnt_q != PEND_MAX) cnt_q <= cnt_q + 1'b1;
                2'b01:   if (cnt_q != '0) cnt_q <= cnt_q - 1'b1;
                default: cnt_q <= cnt_q;
            endcase
        end
    end

    assign nonzero = cnt_q != '0;

endmodule

// File: rtl/dev_chunk_dma.sv
module dev_chunk_dma #(
    parameter int AW      = 32,
    parameter int LEN_W   = 24,
    parameter int CHUNK_W = 8,
    parameter int PEND_W  = 4,
    parameter int DATA_W  = 64
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               arm,
    input  logic [AW-1:0]      cfg_src,
    input  logic [AW-1:0]      cfg_dst,
    input  logic [LEN_W-1:0]   cfg_len,
    input  logic [1:0]         cfg_size,
    input  logic [CHUNK_W-1:0] cfg_chunk,
    input  logic               cfg_src_inc,
    input  logic               cfg_dst_inc,
    input  logic [3:0]         cfg_prio,
    output logic               busy,
    output logic               cfg_err,
    output logic               done,
    input  logic               dev_req,
    output logic               dev_ack,
    output logic               mem_rd_en,
    output logic               mem_wr_en,
    output logic [AW-1:0]      mem_addr,
    output logic [1:0]         mem_size,
    output logic [3:0]         mem_prio,
    output logic [DATA_W-1:0]  mem_wr_data,
    input  logic [DATA_W-1:0]  mem_rd_data,
    input  logic               mem_ready
);
    import dcd_pkg::*;

    dcd_state_e          state_q, state_d;
    logic [LEN_W-1:0]    rem_q;
    logic [CHUNK_W-1:0]  chunk_q;
    logic [CHUNK_W-1:0]  left_q;
    logic [1:0]          size_q;
    logic [3:0]          prio_q;
    logic [DATA_W-1:0]   data_q;
    logic                err_q;

    logic                params_ok;
    logic                arm_ok, arm_bad;
    logic                pend_nz;
    logic                take;
    logic                rd_fire, wr_fire;
    logic                last_in_chunk;
    logic [LEN_W-1:0]    acc_len;
    logic [AW-1:0]       src_addr, dst_addr;

    dcd_param_check #(.AW(AW), .LEN_W(LEN_W), .CHUNK_W(CHUNK_W)) u_check (
        .src       (cfg_src),
        .dst       (cfg_dst),
        .len       (cfg_len),
        .size_code (cfg_size),
        .chunk     (cfg_chunk),
        .ok        (params_ok)
    );

    assign arm_ok  = arm && (state_q == ST_IDLE) && params_ok;
    assign arm_bad = arm && (state_q == ST_IDLE) && !params_ok;
    assign take    = (state_q == ST_WAIT) && (dev_req || pend_nz);
    assign rd_fire = (state_q == ST_READ) && mem_ready;
    assign wr_fire = (state_q == ST_WRITE) && mem_ready;
    assign acc_len = {{(LEN_W-4){1'b0}}, size_bytes(size_q)};
    assign last_in_chunk = (left_q == CHUNK_W'(1)) || (rem_q == acc_len);

    dcd_addr_gen #(.AW(AW)) u_src_gen (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (arm_ok),
        .load_addr (cfg_src),
        .load_inc  (cfg_src_inc),
        .step      (wr_fire),
        .size_code (size_q),
        .addr      (src_addr)
    );

    dcd_addr_gen #(.AW(AW)) u_dst_gen (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (arm_ok),
        .load_addr (cfg_dst),
        .load_inc  (cfg_dst_inc),
        .step      (wr_fire),
        .size_code (size_q),
        .addr      (dst_addr)
    );

    dcd_pend_ctr #(.PEND_W(PEND_W)) u_pend (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (arm_ok),
        .inc     (dev_req && (state_q != ST_IDLE)),
        .dec     (take),
        .nonzero (pend_nz)
    );

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (arm_ok) state_d = ST_WAIT;
            ST_WAIT:  if (take) state_d = ST_READ;
            ST_READ:  if (mem_ready) state_d = ST_WRITE;
            ST_WRITE: if (mem_ready) state_d = last_in_chunk ? ST_ACK : ST_READ;
            ST_ACK:   state_d = (rem_q == '0) ? ST_IDLE : ST_WAIT;
            default:  state_d = ST_IDLE;
        endcase
    end

    // datapath registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rem_q   <= '0;
            chunk_q <= '0;
            left_q  <= '0;
            size_q  <= '0;
            prio_q  <= '0;
            data_q  <= '0;
            err_q   <= 1'b0;
        end else begin
            if (arm_ok) begin
                rem_q   <= cfg_len;
                chunk_q <= cfg_chunk;
                size_q  <= cfg_size;
                prio_q  <= cfg_prio;
                err_q   <= 1'b0;
            end else if (arm_bad) begin
                err_q   <= 1'b1;
            end
            if (take)    left_q <= chunk_q;
            if (rd_fire) data_q <= mem_rd_data;
            if (wr_fire) begin
                rem_q  <= rem_q - acc_len;
                left_q <= left_q - 1'b1;
            end
        end
    end

    // outputs
    always_comb begin
        mem_rd_en = 1'b0;
        mem_wr_en = 1'b0;
        mem_addr  = dst_addr;
        dev_ack   = 1'b0;
        done      = 1'b0;
        unique case (state_q)
            ST_IDLE, ST_WAIT: ;
            ST_READ: begin
                mem_rd_en = 1'b1;
                mem_addr  = src_addr;
            end
            ST_WRITE: mem_wr_en = 1'b1;
            ST_ACK: begin
                dev_ack = 1'b1;
                done    = (rem_q == '0);
            end
            default: ;
        endcase
    end

    assign busy        = state_q != ST_IDLE;
    assign cfg_err     = err_q;
    assign mem_size    = size_q;
    assign mem_prio    = prio_q;
    assign mem_wr_data = data_q;

endmodule

// File: rtl/dev_chunk_dma_chk.sv
module dev_chunk_dma_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       busy,
    input logic       cfg_err,
    input logic       done,
    input logic       dev_ack,
    input logic       mem_rd_en,
    input logic       mem_wr_en,
    input logic       mem_ready,
    input logic [1:0] mem_size,
    input logic [3:0] mem_prio
);

    a_r3_rd_wr_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_rd_en && mem_wr_en));

    a_r3_write_follows_read: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_wr_en) |-> $past(mem_rd_en && mem_ready));

    a_r8_ack_single_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        dev_ack |=> !dev_ack);

    a_r8_done_with_ack: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> dev_ack);

    a_r8_idle_after_done: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !busy);

    a_r1_size_steady: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> $stable(mem_size));

    a_r9_prio_steady: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> $stable(mem_prio));

    a_r2_err_only_idle: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_err |-> !busy);

    a_r10_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (!mem_rd_en && !mem_wr_en));

endmodule

bind dev_chunk_dma dev_chunk_dma_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .busy      (busy),
    .cfg_err   (cfg_err),
    .done      (done),
    .dev_ack   (dev_ack),
    .mem_rd_en (mem_rd_en),
    .mem_wr_en (mem_wr_en),
    .mem_ready (mem_ready),
    .mem_size  (mem_size),
    .mem_prio  (mem_prio)
);

// File: tb/dev_chunk_dma_bench.sv
`timescale 1ns/1ps
module dev_chunk_dma_bench;

    localparam int AW = 8, LEN_W = 12, CHUNK_W = 4, PEND_W = 3, DATA_W = 64;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #2.5 clk = ~clk;

    logic               arm = 1'b0;
    logic [AW-1:0]      cfg_src = '0, cfg_dst = '0;
    logic [LEN_W-1:0]   cfg_len = '0;
    logic [1:0]         cfg_size = '0;
    logic [CHUNK_W-1:0] cfg_chunk = '0;
    logic               cfg_src_inc = 1'b0, cfg_dst_inc = 1'b0;
    logic [3:0]         cfg_prio = '0;
    logic               busy, cfg_err, done, dev_ack;
    logic               dev_req = 1'b0;
    logic               mem_rd_en, mem_wr_en;
    logic [AW-1:0]      mem_addr;
    logic [1:0]         mem_size;
    logic [3:0]         mem_prio;
    logic [DATA_W-1:0]  mem_wr_data;
    logic [DATA_W-1:0]  mem_rd_data = '0;
    logic               mem_ready = 1'b1;

    dev_chunk_dma #(.AW(AW), .LEN_W(LEN_W), .CHUNK_W(CHUNK_W), .PEND_W(PEND_W), .DATA_W(DATA_W)) u_dev_chunk_dma (
        .clk(clk), .rst_n(rst_n), .arm(arm),
        .cfg_src(cfg_src), .cfg_dst(cfg_dst), .cfg_len(cfg_len), .cfg_size(cfg_size),
        .cfg_chunk(cfg_chunk), .cfg_src_inc(cfg_src_inc), .cfg_dst_inc(cfg_dst_inc),
        .cfg_prio(cfg_prio), .busy(busy), .cfg_err(cfg_err), .done(done),
        .dev_req(dev_req), .dev_ack(dev_ack),
        .mem_rd_en(mem_rd_en), .mem_wr_en(mem_wr_en), .mem_addr(mem_addr),
        .mem_size(mem_size), .mem_prio(mem_prio), .mem_wr_data(mem_wr_data),
        .mem_rd_data(mem_rd_data), .mem_ready(mem_ready)
    );

    int checks = 0, fails = 0;
    bit finished = 0;

    logic [7:0] mem [0:255];
    logic [7:0] expm [0:255];

    // transfer under test
    int g_src, g_dst, g_acc, g_n, g_chunk, g_prio, g_sc;
    bit g_si, g_di;
    int rd_idx, wr_idx, acks, chunk_wr;
    bit prev_ack;

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // one cycle of memory service and observation, then advance to next negedge
    task automatic service(input bit stall);
        int nch, exp_cnt, sa, da;
        mem_ready = stall ? (($urandom % 4) != 0) : 1'b1;
        #0.5;
        if (mem_rd_en) begin
            mem_rd_data = '0;
            for (int b = 0; b < (1 << mem_size); b++)
                mem_rd_data[8*b +: 8] = mem[(int'(mem_addr) + b) & 255];
            if (mem_ready) begin
                sa = g_src + (g_si ? rd_idx * g_acc : 0);
                chk(mem_addr == AW'(sa), "R5 source address", mem_addr, sa);
                chk(mem_size == 2'(g_sc), "R1 access size code", mem_size, g_sc);
                chk(mem_prio == 4'(g_prio), "R9 priority", mem_prio, g_prio);
                rd_idx++;
            end
        end
        if (mem_wr_en && mem_ready) begin
            da = g_dst + (g_di ? wr_idx * g_acc : 0);
            chk(mem_addr == AW'(da), "R6 destination address", mem_addr, da);
            for (int b = 0; b < (1 << mem_size); b++)
                mem[(int'(mem_addr) + b) & 255] = mem_wr_data[8*b +: 8];
            wr_idx++;
            chunk_wr++;
        end
        if (dev_ack) begin
            nch = (g_n + g_chunk - 1) / g_chunk;
            exp_cnt = (g_n - acks * g_chunk < g_chunk) ? g_n - acks * g_chunk : g_chunk;
            if (exp_cnt < g_chunk)
                chk(chunk_wr == exp_cnt, "R4 partial chunk accesses", chunk_wr, exp_cnt);
            else
                chk(chunk_wr == exp_cnt, "R3 chunk accesses", chunk_wr, exp_cnt);
            chk(done == (acks == nch - 1), "R8 done with final ack", done, acks == nch - 1);
            chk(!prev_ack, "R8 ack one cycle", prev_ack, 0);
            acks++;
            chunk_wr = 0;
        end
        prev_ack = dev_ack;
        @(negedge clk);
    endtask

    task automatic setup(input int src, input int dst, input int len, input int sc,
                         input int chunk, input bit si, input bit di, input int prio);
        g_src = src; g_dst = dst; g_sc = sc; g_acc = 1 << sc; g_n = len / g_acc;
        g_chunk = chunk; g_si = si; g_di = di; g_prio = prio;
        rd_idx = 0; wr_idx = 0; acks = 0; chunk_wr = 0; prev_ack = 0;
        for (int a = 0; a < 256; a++) mem[a] = 8'((a * 37 + src + len + sc) ^ 8'h5a);
        for (int a = 0; a < 256; a++) expm[a] = mem[a];
        for (int k = 0; k < g_n; k++) begin
            int sa, da;
            sa = src + (si ? k * g_acc : 0);
            da = dst + (di ? k * g_acc : 0);
            for (int b = 0; b < g_acc; b++) expm[(da + b) & 255] = expm[(sa + b) & 255];
        end
        cfg_src = AW'(src); cfg_dst = AW'(dst); cfg_len = LEN_W'(len);
        cfg_size = 2'(sc); cfg_chunk = CHUNK_W'(chunk);
        cfg_src_inc = si; cfg_dst_inc = di; cfg_prio = 4'(prio);
        arm = 1'b1;
        @(negedge clk);
        arm = 1'b0;
    endtask

    task automatic compare_mem(input string req);
        int bad;
        bad = 0;
        for (int a = 0; a < 256; a++) if (mem[a] !== expm[a]) bad++;
        chk(bad == 0, req, bad, 0);
    endtask

    task automatic run_xfer(input int src, input int dst, input int len, input int sc,
                            input int chunk, input bit si, input bit di, input int prio);
        int nch;
        setup(src, dst, len, sc, chunk, si, di, prio);
        chk(busy && !cfg_err, "R2 valid arm accepted", {busy, cfg_err}, 2);
        nch = (g_n + chunk - 1) / chunk;
        for (int c = 0; c < nch; c++) begin
            int guard;
            dev_req = 1'b1;
            @(negedge clk);
            dev_req = 1'b0;
            guard = 0;
            while (acks == c && guard < 300) begin
                service(1'b1);
                guard++;
            end
        end
        chk(acks == nch, "R3 acknowledge count", acks, nch);
        chk(!busy, "R8 idle after final ack", busy, 0);
        compare_mem("R3 memory image after transfer");
    endtask

    task automatic bad_arm(input int src, input int dst, input int len, input int sc, input int chunk);
        int seen;
        setup(src, dst, len, sc, chunk, 1'b1, 1'b1, 3);
        chk(cfg_err && !busy, "R2 rejected arm", {cfg_err, busy}, 2);
        dev_req = 1'b1;
        @(negedge clk);
        dev_req = 1'b0;
        seen = 0;
        for (int i = 0; i < 6; i++) begin
            if (mem_rd_en || mem_wr_en || busy) seen++;
            @(negedge clk);
        end
        chk(seen == 0, "R10 request while idle ignored", seen, 0);
    endtask

    initial begin
        #(5.0 * 150000);
        if (!finished) begin
            checks++;
            fails++;
            $display("FAIL watchdog expired actual=hung expected=finished");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        chk(!busy && !cfg_err && !done && !dev_ack && !mem_rd_en && !mem_wr_en,
            "R11 reset state", {busy, cfg_err, done, dev_ack, mem_rd_en, mem_wr_en}, 0);
        rst_n = 1'b1;
        @(negedge clk);

        // sweep size x flags x chunk shape (full and partial last chunk)
        for (int sc = 0; sc < 4; sc++)
            for (int fl = 0; fl < 4; fl++)
                for (int ch = 1; ch <= 3; ch += 2)
                    run_xfer(8'h10, 8'h80, (1 << sc) * 5, sc, ch, fl[0], fl[1], (sc * 4 + fl) & 15);

        // chunk evenly dividing the transfer, maximum priority
        run_xfer(8'h20, 8'h60, 16, 1, 4, 1'b1, 1'b1, 15);

        // rejections
        bad_arm(8'h11, 8'h80, 8, 1, 2);   // misaligned source
        bad_arm(8'h10, 8'h84, 16, 3, 2);  // misaligned destination
        bad_arm(8'h10, 8'h80, 6, 2, 2);   // length not a multiple
        bad_arm(8'h10, 8'h80, 0, 0, 2);   // zero length
        bad_arm(8'h10, 8'h80, 8, 0, 0);   // zero chunk

        // queued requests plus arm while busy
        begin
            int guard;
            setup(8'h40, 8'hA0, 24, 2, 2, 1'b1, 1'b1, 6);
            chk(!cfg_err && busy, "R2 valid arm clears error", {cfg_err, busy}, 1);
            for (int i = 0; i < 3; i++) begin
                dev_req = 1'b1;
                service(1'b0);
            end
            dev_req = 1'b0;
            cfg_src = 8'h41; cfg_len = 12'd3; cfg_prio = 4'd1;
            arm = 1'b1;
            service(1'b1);
            arm = 1'b0;
            chk(!cfg_err, "R10 arm while busy ignored", cfg_err, 0);
            guard = 0;
            while (busy && guard < 400) begin
                service(1'b1);
                guard++;
            end
            chk(acks == 3, "R7 queued requests served", acks, 3);
            chk(wr_idx == 6, "R7 total accesses", wr_idx, 6);
            compare_mem("R10 memory unaffected by arm while busy");
        end

        finished = 1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule